// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register File

This block keeps the software-visible control state of a two-channel bus-master disk DMA engine. Each channel has three registers: a command byte (run bit and transfer direction), a status byte (active, error, interrupt and two drive-capability flags) and a 32-bit descriptor table pointer. Software reaches them through a simple single-cycle register bus with byte, word and dword access sizes. Reads return their data one cycle later.

The block tells the data-movement engine when to run. Setting the run bit emits a one-cycle start pulse that carries the pointer in force at that moment. Clearing it emits a stop pulse. The engine reports the end of a transfer on a per-channel completion input and reports faults on a per-channel fault input. The block folds both into the status bits.

Two enables gate the block. The I/O enable gates every access. The bus-master enable also gates writes. A write of the wrong size to a control register is discarded and latches a sticky error output.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, both status registers read 0x60 (capability flags at bits 5 and 6 set), and every command and pointer register reads zero. The size error output is low.
- R2: A write takes effect only when both io_en and bm_en are high. Otherwise the register and the pulse outputs are unchanged. A read issued while io_en is low returns zero.
- R3: Byte offsets 0 to 7 belong to channel 0 and offsets 8 to 15 to channel 1. Within a channel, the command register is at +0, the status register at +2 and the pointer at +4..+7. Each channel's registers are independent of the other's.
- R4: The command register keeps only bit 0 (run) and bit 3 (direction). When a command write takes the run bit from 0 to 1, status bit 0 (active) is set and start_pulse goes high for one cycle in the cycle after the write, with start_ptr holding the pointer. When the write takes the run bit from 1 to 0, active is cleared and stop_pulse goes high for one cycle.
- R5: While the run bit is set, a command write leaves the direction bit unchanged.
- R6: A status write never changes the active bit.
- R7: The pointer stores bits 1:0 as zero.
- R8: A dma_done pulse on a channel clears its run bit and its active bit and sets its interrupt bit (status bit 2).
- R9: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 and left unchanged by writing 0. xfer_fault sets bit 1. Bits 5 and 6 are plain read/write storage.
- R10: Command and status writes must use byte size, and pointer writes must use dword size. Any other size is dropped and sets size_err, which stays high until reset.
- R11: The size code is 0 for byte, 1 for word and 2 for dword. rdata updates one cycle after rd_en and holds the little-endian bytes starting at addr, with the bytes beyond the access size reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | Gates all register accesses |
| bm_en | input | 1 | Gates register writes |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| size | input | 2 | Access size code |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Registered read data |
| dma_done | input | NUM_CH | Per-channel transfer completion |
| xfer_fault | input | NUM_CH | Per-channel transfer fault |
| start_pulse | output | NUM_CH | One-cycle start request per channel |
| stop_pulse | output | NUM_CH | One-cycle stop request per channel |
| start_ptr | output | NUM_CH x 32 | Table pointer captured at start |
| size_err | output | 1 | Sticky illegal-size write flag |

## Verification
The bench tries to flip the direction bit while a transfer runs. A design without the lock would read the new direction back. It writes zero to the status register while active is set; a design that lets software write that bit would show active cleared. It writes 1 and then 0 to the interrupt and error bits to separate write-one-to-clear from plain storage, and it drives the completion input to confirm that run clears while direction survives. It also issues writes with the enables low and with illegal sizes. A design that honoured any of these would emit a pulse or change the command register.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
   localparam int unsigned PTR_W     = 32;
   localparam int unsigned STRIDE_W  = 3;
   localparam int unsigned CH_STRIDE = 8;

   localparam int unsigned CMD_RUN  = 0;
   localparam int unsigned CMD_DIR  = 3;
   localparam int unsigned STS_ACT  = 0;
   localparam int unsigned STS_ERR  = 1;
   localparam int unsigned STS_IRQ  = 2;
   localparam int unsigned STS_CAP0 = 5;
   localparam int unsigned STS_CAP1 = 6;

   localparam logic [7:0] CMD_KEEP  = 8'h09;
   localparam logic [7:0] STS_RESET = 8'h60;

   localparam logic [STRIDE_W-1:0] OFS_CMD = 3'd0;
   localparam logic [STRIDE_W-1:0] OFS_STS = 3'd2;
   localparam logic [STRIDE_W-1:0] OFS_PTR = 3'd4;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_WORD  = 2'b01,
      SZ_DWORD = 2'b10,
      SZ_BAD   = 2'b11
   } acc_size_e;

   typedef struct packed {
      logic cmd;
      logic sts;
      logic ptr;
   } reg_sel_t;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
   import bmdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned NUM_CH = 2
) (
   input  logic              wr_en,
   input  logic              io_en,
   input  logic              bm_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output reg_sel_t [NUM_CH-1:0] sel,
   output logic              size_fault
);
   localparam int unsigned CH_W = ADDR_W - STRIDE_W;

   logic                wr_ok;
   logic [STRIDE_W-1:0] loc;
   logic [CH_W-1:0]     ch_idx;
   logic                is_byte;
   logic                is_dword;
   logic [NUM_CH-1:0]   bad;

   assign wr_ok    = wr_en & io_en & bm_en;
   assign loc      = addr[STRIDE_W-1:0];
   assign ch_idx   = addr[ADDR_W-1:STRIDE_W];
   assign is_byte  = (acc_size_e'(size) == SZ_BYTE);
   assign is_dword = (acc_size_e'(size) == SZ_DWORD);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      logic at_cmd, at_sts, at_ptr;
      assign hit    = wr_ok && (ch_idx == CH_W'(c));
      assign at_cmd = hit && (loc == OFS_CMD);
      assign at_sts = hit && (loc == OFS_STS);
      assign at_ptr = hit && (loc == OFS_PTR);
      assign sel[c].cmd = at_cmd && is_byte;
      assign sel[c].sts = at_sts && is_byte;
      assign sel[c].ptr = at_ptr && is_dword;
      assign bad[c] = ((at_cmd || at_sts) && !is_byte) || (at_ptr && !is_dword);
   end

   assign size_fault = |bad;
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
   import bmdma_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic             sts_we,
   input  logic             ptr_we,
   input  logic [7:0]       wbyte,
   input  logic [PTR_W-1:0] wptr,
   input  logic             done,
   input  logic             fault,
   output logic [7:0]       cmd,
   output logic [7:0]       sts,
   output logic [PTR_W-1:0] ptr,
   output logic             start_p,
   output logic             stop_p,
   output logic [PTR_W-1:0] start_ptr
);
   logic [7:0]       cmd_q, cmd_n, nb;
   logic [7:0]       sts_q, sts_n;
   logic [PTR_W-1:0] ptr_q, ptr_n;
   logic             go, halt;
   logic             start_q, stop_q;
   logic [PTR_W-1:0] sptr_q;

   always_comb begin
      cmd_n = cmd_q;
      sts_n = sts_q;
      ptr_n = ptr_q;
      go    = 1'b0;
      halt  = 1'b0;
      nb    = wbyte & CMD_KEEP;
      if (cmd_q[CMD_RUN]) begin
         nb[CMD_DIR] = cmd_q[CMD_DIR];
      end
      if (cmd_we) begin
         if (!cmd_q[CMD_RUN] && nb[CMD_RUN]) begin
            go = 1'b1;
            sts_n[STS_ACT] = 1'b1;
         end
         if (cmd_q[CMD_RUN] && !nb[CMD_RUN]) begin
            halt = 1'b1;
            sts_n[STS_ACT] = 1'b0;
         end
         cmd_n = nb;
      end
      if (sts_we) begin
         sts_n[STS_CAP0] = wbyte[STS_CAP0];
         sts_n[STS_CAP1] = wbyte[STS_CAP1];
         if (wbyte[STS_ERR]) sts_n[STS_ERR] = 1'b0;
         if (wbyte[STS_IRQ]) sts_n[STS_IRQ] = 1'b0;
      end
      if (ptr_we) begin
         ptr_n = {wptr[PTR_W-1:2], 2'b00};
      end
      if (fault) begin
         sts_n[STS_ERR] = 1'b1;
      end
      if (done) begin
         cmd_n[CMD_RUN] = 1'b0;
         sts_n[STS_ACT] = 1'b0;
         sts_n[STS_IRQ] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         sts_q   <= STS_RESET;
         ptr_q   <= '0;
         start_q <= 1'b0;
         stop_q  <= 1'b0;
         sptr_q  <= '0;
      end else begin
         cmd_q   <= cmd_n;
         sts_q   <= sts_n;
         ptr_q   <= ptr_n;
         start_q <= go;
         stop_q  <= halt;
         if (go) sptr_q <= ptr_q;
      end
   end

   assign cmd       = cmd_q;
   assign sts       = sts_q;
   assign ptr       = ptr_q;
   assign start_p   = start_q;
   assign stop_p    = stop_q;
   assign start_ptr = sptr_q;
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
   import bmdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned NUM_CH = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_en,
   input  logic                         io_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [1:0]                   size,
   input  logic [NUM_CH-1:0][7:0]       cmd,
   input  logic [NUM_CH-1:0][7:0]       sts,
   input  logic [NUM_CH-1:0][PTR_W-1:0] ptr,
   output logic [31:0]                  rdata
);
   localparam int unsigned NBYTES = 2 ** ADDR_W;

   logic [NBYTES-1:0][7:0] view;
   logic [31:0]            gathered;
   logic [31:0]            mask;
   logic [31:0]            rdata_q;

   for (genvar i = 0; i < NBYTES; i++) begin : g_view
      localparam int unsigned CH  = i / CH_STRIDE;
      localparam int unsigned LOC = i % CH_STRIDE;
      if (CH >= NUM_CH) begin : g_none
         assign view[i] = 8'h00;
      end else if (LOC == int'(OFS_CMD)) begin : g_cmd
         assign view[i] = cmd[CH];
      end else if (LOC == int'(OFS_STS)) begin : g_sts
         assign view[i] = sts[CH];
      end else if (LOC >= int'(OFS_PTR)) begin : g_ptr
         assign view[i] = ptr[CH][8*(LOC-int'(OFS_PTR)) +: 8];
      end else begin : g_rsvd
         assign view[i] = 8'h00;
      end
   end

   always_comb begin
      for (int k = 0; k < 4; k++) begin
         gathered[8*k +: 8] = view[addr + ADDR_W'(k)];
      end
      case (acc_size_e'(size))
         SZ_BYTE:  mask = 32'h0000_00FF;
         SZ_WORD:  mask = 32'h0000_FFFF;
         SZ_DWORD: mask = 32'hFFFF_FFFF;
         default:  mask = 32'h0000_0000;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= io_en ? (gathered & mask) : 32'h0;
      end
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
   import bmdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned NUM_CH = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         io_en,
   input  logic                         bm_en,
   input  logic                         wr_en,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [1:0]                   size,
   input  logic [31:0]                  wdata,
   output logic [31:0]                  rdata,
   input  logic [NUM_CH-1:0]            dma_done,
   input  logic [NUM_CH-1:0]            xfer_fault,
   output logic [NUM_CH-1:0]            start_pulse,
   output logic [NUM_CH-1:0]            stop_pulse,
   output logic [NUM_CH-1:0][PTR_W-1:0] start_ptr,
   output logic                         size_err
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("bmdma_regfile: NUM_CH must be at least 1");
   end
   if (NUM_CH * CH_STRIDE > 2 ** ADDR_W) begin : g_bad_addr
      $error("bmdma_regfile: ADDR_W too small for NUM_CH channels");
   end
   if (ADDR_W <= STRIDE_W) begin : g_bad_w
      $error("bmdma_regfile: ADDR_W must exceed the channel stride width");
   end

   reg_sel_t [NUM_CH-1:0]        sel;
   logic                         size_fault;
   logic [NUM_CH-1:0][7:0]       cmd_v;
   logic [NUM_CH-1:0][7:0]       sts_v;
   logic [NUM_CH-1:0][PTR_W-1:0] ptr_v;
   logic                         size_err_q;

   bmdma_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) i_decode (
      .wr_en      (wr_en),
      .io_en      (io_en),
      .bm_en      (bm_en),
      .addr       (addr),
      .size       (size),
      .sel        (sel),
      .size_fault (size_fault)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      bmdma_chan i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd_we    (sel[c].cmd),
         .sts_we    (sel[c].sts),
         .ptr_we    (sel[c].ptr),
         .wbyte     (wdata[7:0]),
         .wptr      (wdata[PTR_W-1:0]),
         .done      (dma_done[c]),
         .fault     (xfer_fault[c]),
         .cmd       (cmd_v[c]),
         .sts       (sts_v[c]),
         .ptr       (ptr_v[c]),
         .start_p   (start_pulse[c]),
         .stop_p    (stop_pulse[c]),
         .start_ptr (start_ptr[c])
      );
   end

   bmdma_rdmux #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) i_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (rd_en),
      .io_en (io_en),
      .addr  (addr),
      .size  (size),
      .cmd   (cmd_v),
      .sts   (sts_v),
      .ptr   (ptr_v),
      .rdata (rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_err_q <= 1'b0;
      end else if (size_fault) begin
         size_err_q <= 1'b1;
      end
   end

   assign size_err = size_err_q;
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk
   import bmdma_pkg::*;
#(
   parameter int unsigned NUM_CH = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         io_en,
   input logic                         bm_en,
   input logic                         wr_en,
   input logic [NUM_CH-1:0]            start_pulse,
   input logic [NUM_CH-1:0]            stop_pulse,
   input logic [NUM_CH-1:0][PTR_W-1:0] start_ptr,
   input logic                         size_err
);
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      size_err |=> size_err); // R10

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(start_pulse[c] && stop_pulse[c])); // R4
      AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         start_pulse[c] |-> $past(wr_en && io_en && bm_en)); // R2
      AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         stop_pulse[c] |-> $past(wr_en && io_en && bm_en)); // R2
      AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
         start_pulse[c] |-> (start_ptr[c][1:0] == 2'b00)); // R7
   end
endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NUM_CH(NUM_CH)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_en       (io_en),
   .bm_en       (bm_en),
   .wr_en       (wr_en),
   .start_pulse (start_pulse),
   .stop_pulse  (stop_pulse),
   .start_ptr   (start_ptr),
   .size_err    (size_err)
);

// File: tb/test_bmdma_regfile.sv
module test_bmdma_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int NC = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              io_en = 1'b1;
   logic              bm_en = 1'b1;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [1:0]        size = 2'b00;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [NC-1:0]     dma_done = '0;
   logic [NC-1:0]     xfer_fault = '0;
   logic [NC-1:0]     start_pulse;
   logic [NC-1:0]     stop_pulse;
   logic [NC-1:0][31:0] start_ptr;
   logic              size_err;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   typedef struct {
      logic [31:0] v;
      string       tag;
   } exp_t;
   exp_t sb[$];
   logic rd_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bmdma_regfile #(.ADDR_W(AW), .NUM_CH(NC)) i_bmdma_regfile (
      .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .size(size),
      .wdata(wdata), .rdata(rdata), .dma_done(dma_done),
      .xfer_fault(xfer_fault), .start_pulse(start_pulse),
      .stop_pulse(stop_pulse), .start_ptr(start_ptr), .size_err(size_err)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) rd_seen <= rd_en;

   // scoreboard monitor: pops one expected item per completed read
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R11 unexpected read data actual=%h expected=none", rdata);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, rdata, e.v);
         end
      end
   end

   task automatic wr(logic [AW-1:0] a, logic [1:0] s, logic [31:0] d);
      addr = a; size = s; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [1:0] s, logic [31:0] e, string tag);
      exp_t it;
      it.v = e; it.tag = tag;
      sb.push_back(it);
      addr = a; size = s; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_done(int c);
      dma_done[c] = 1'b1;
      @(negedge clk);
      dma_done[c] = 1'b0;
   endtask

   task automatic pulse_fault(int c);
      xfer_fault[c] = 1'b1;
      @(negedge clk);
      xfer_fault[c] = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 size_err at reset", {31'b0, size_err}, 32'h0);
      rd(4'd2,  2'd0, 32'h60, "R1 status0 reset");
      rd(4'd10, 2'd0, 32'h60, "R1 status1 reset");
      rd(4'd0,  2'd0, 32'h00, "R1 cmd0 reset");
      rd(4'd4,  2'd2, 32'h0,  "R1 ptr0 reset");

      // R7 pointer alignment
      wr(4'd4, 2'd2, 32'h1234_5677);
      rd(4'd4, 2'd2, 32'h1234_5674, "R7 ptr0 low bits zero");

      // R4 start edge
      wr(4'd0, 2'd0, 32'h0000_00FF);
      check("R4 start pulse ch0", {30'b0, start_pulse}, 32'h1);
      check("R4 start ptr ch0", start_ptr[0], 32'h1234_5674);
      check("R4 no stop on start", {30'b0, stop_pulse}, 32'h0);
      @(negedge clk);
      check("R4 start pulse one cycle", {30'b0, start_pulse}, 32'h0);
      rd(4'd2, 2'd0, 32'h61, "R4 active set");
      rd(4'd0, 2'd0, 32'h09, "R4 cmd keeps bits 0 and 3");

      // R5 direction lock
      wr(4'd0, 2'd0, 32'h01);
      check("R5 no pulse on rewrite", {28'b0, start_pulse, stop_pulse}, 32'h0);
      rd(4'd0, 2'd0, 32'h09, "R5 direction locked");

      // R6 active read-only, R9 caps writable
      wr(4'd2, 2'd0, 32'h00);
      rd(4'd2, 2'd0, 32'h01, "R6 active kept, R9 caps cleared");
      wr(4'd2, 2'd0, 32'h60);
      rd(4'd2, 2'd0, 32'h61, "R9 caps written");

      // R8 completion
      pulse_done(0);
      rd(4'd0, 2'd0, 32'h08, "R8 run cleared dir kept");
      rd(4'd2, 2'd0, 32'h64, "R8 active clear irq set");

      // R9 write-one-to-clear
      wr(4'd2, 2'd0, 32'h60);
      rd(4'd2, 2'd0, 32'h64, "R9 irq kept on write 0");
      wr(4'd2, 2'd0, 32'h64);
      rd(4'd2, 2'd0, 32'h60, "R9 irq cleared on write 1");
      pulse_fault(0);
      rd(4'd2, 2'd0, 32'h62, "R9 fault sets error");
      wr(4'd2, 2'd0, 32'h62);
      rd(4'd2, 2'd0, 32'h60, "R9 error cleared on write 1");

      // R3 channel 1 independence
      wr(4'd12, 2'd2, 32'hABCD_0003);
      rd(4'd12, 2'd2, 32'hABCD_0000, "R3 ptr1");
      wr(4'd8, 2'd0, 32'h01);
      check("R3 start pulse ch1", {30'b0, start_pulse}, 32'h2);
      check("R3 start ptr ch1", start_ptr[1], 32'hABCD_0000);
      rd(4'd10, 2'd0, 32'h61, "R3 status1 active");
      rd(4'd2,  2'd0, 32'h60, "R3 status0 untouched");
      wr(4'd8, 2'd0, 32'h00);
      check("R4 stop pulse ch1", {30'b0, stop_pulse}, 32'h2);
      check("R4 no start on stop", {30'b0, start_pulse}, 32'h0);
      rd(4'd10, 2'd0, 32'h60, "R4 active cleared by stop");

      // R2 enable gating
      bm_en = 1'b0;
      wr(4'd0, 2'd0, 32'h01);
      check("R2 no pulse bm_en low", {30'b0, start_pulse}, 32'h0);
      rd(4'd0, 2'd0, 32'h08, "R2 cmd unchanged bm_en low");
      bm_en = 1'b1;
      io_en = 1'b0;
      wr(4'd0, 2'd0, 32'h01);
      check("R2 no pulse io_en low", {30'b0, start_pulse}, 32'h0);
      rd(4'd4, 2'd2, 32'h0, "R2 read zero io_en low");
      io_en = 1'b1;
      rd(4'd0, 2'd0, 32'h08, "R2 cmd unchanged io_en low");

      // R10 illegal sizes
      check("R10 size_err before", {31'b0, size_err}, 32'h0);
      wr(4'd0, 2'd2, 32'h01);
      check("R10 no pulse on bad size", {30'b0, start_pulse}, 32'h0);
      check("R10 size_err set", {31'b0, size_err}, 32'h1);
      rd(4'd0, 2'd0, 32'h08, "R10 cmd unchanged bad size");
      wr(4'd4, 2'd0, 32'hFF);
      rd(4'd4, 2'd2, 32'h1234_5674, "R10 ptr unchanged byte write");
      wr(4'd2, 2'd0, 32'h60);
      check("R10 size_err sticky", {31'b0, size_err}, 32'h1);

      // R11 read formatting
      rd(4'd0, 2'd2, 32'h0060_0008, "R11 dword read ch0");
      rd(4'd2, 2'd1, 32'h0000_0060, "R11 word read");
      rd(4'd5, 2'd0, 32'h0000_0056, "R11 byte read of ptr");
      rd(4'd8, 2'd2, 32'h0060_0000, "R11 dword read ch1");

      repeat (2) @(negedge clk);
      check("R11 scoreboard drained", sb.size(), 32'h0);
      finish_run();
   end
endmodule